// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor side of a four-channel DMA controller: the register file and the decoder for software commands. A host reaches it through an 8-bit data port with separate input and output buses, a 4-bit address and active-low chip select, read strobe and write strobe. It holds the command, mode, mask, request, status and temporary registers, and a 16-bit address register and a 16-bit count register for each channel. These 16-bit registers are reached one byte at a time through a byte-order flip-flop.

The transfer engine sits beside this block. It sends terminal-count pulses, hardware request levels and a temporary-data load into the block. It reads the programmed command, mode, mask, software-request and per-channel address and count values from the block's outputs. A master-clear pulse output tells the engine to return to idle.

An access is one clock cycle in which chip select is low and exactly one of the two strobes is low. The block acts on that access at the clock edge that ends the cycle. Read data is driven combinationally during the read cycle. Some commands fire on the access itself and take no notice of the data bus.

Top module: `dma_regif`

## Requirements
- R1: After reset the command, request, status and temporary registers are zero, all four mask bits are set, the byte flip-flop selects the low byte, and the mode-read counter points at channel 0.
- R2: With address bit 3 low, address bits 2:1 pick a channel and address bit 0 picks the address register (0) or the count register (1). Each read or write of one of these takes the low byte (bits 7:0) when the byte flip-flop is clear and the high byte (bits 15:8) when it is set, then toggles the flip-flop.
- R3: A read at address 0xC sets the byte flip-flop and a write at 0xC clears it.
- R4: A read at 0x8 returns the status byte. Bits 3:0 are the terminal-count flags of channels 0 to 3. Bits 7:4 are the request flags of channels 0 to 3, taken one cycle after the OR of the hardware request level and the software request bit.
- R5: A status read clears all terminal-count flags. A terminal-count pulse in the same cycle as the status read leaves its flag set.
- R6: A write at 0x8 loads the command register, and a read at 0xA returns it.
- R7: A write at 0xA changes one mask bit: data bits 1:0 give the channel and data bit 2 gives the new value. A write at 0xF loads all four mask bits from data bits 3:0. A write at 0xE clears all mask bits. A read at 0xF returns the mask in bits 3:0, with bits 7:4 zero.
- R8: A write at 0x9 changes one software request bit, with the same field layout as the single-mask write. A read at 0x9 returns the request bits in bits 3:0, with bits 7:4 zero.
- R9: A write at 0xB stores data bits 7:2 as the mode of the channel given by data bits 1:0. A read at 0xB returns the mode of the channel the counter points at, with bits 1:0 read as 1, and then advances the counter (3 wraps to 0). A read at 0xE resets the counter to channel 0.
- R10: A temporary-load pulse from the engine captures the engine's data byte into the temporary register. A read at 0xD returns that register.
- R11: A write at 0xD is a master clear. It has the reset effect of R1 on the command, request, status and temporary registers, the byte flip-flop, the counter and the mask. It pulses the master-clear output in the same cycle. Mode, address and count registers keep their values.
- R12: The set/clear flip-flop, master clear, counter clear and clear-mask commands ignore the data bus. The read-type commands at 0xC and 0xE return 0x00.
- R13: A cycle with chip select high, or with both strobes low, is not an access. It changes no register and read data stays 0x00. Outside a read access the read data output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, 0x00 outside a read access |
| tc_i | input | 4 | Terminal-count pulse per channel |
| hw_req_i | input | 4 | Hardware request level per channel |
| temp_we_i | input | 1 | Temporary register load strobe |
| temp_i | input | 8 | Byte to store in the temporary register |
| cmd_o | output | 8 | Command register |
| mode_o | output | 24 | Mode bits 7:2 of each channel, channel 0 in the low six bits |
| mask_o | output | 4 | Mask bits |
| sw_req_o | output | 4 | Software request bits |
| chan_addr_o | output | 64 | Address register per channel, channel 0 in bits 15:0 |
| chan_count_o | output | 64 | Count register per channel, channel 0 in bits 15:0 |
| mclr_o | output | 1 | Master-clear pulse |

## Verification
The assertions check on every cycle these properties:
- a terminal-count pulse always leaves its flag set;
- a master clear leaves the mask all set and the command and request registers empty;
- a clear-mask write leaves the mask empty;
- a command write lands in the command register;
- mode reads always show ones in the two low bits;
- each channel-register access toggles the byte flip-flop;
- a cycle without chip select changes nothing.

Byte ordering across a sequence of accesses, the order and wrap of the mode-read sequencer, the one-cycle lag of the request flags, and the survival of mode and channel registers through a master clear can only be shown by the bench's scenarios. The bench shows these by comparing against its reference model and by directed reads with known values.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

  typedef struct packed {
    logic chan_rd;
    logic chan_wr;
    logic stat_rd;
    logic cmd_wr;
    logic req_rd;
    logic req_wr;
    logic cmd_rd;
    logic smask_wr;
    logic mode_rd;
    logic mode_wr;
    logic ff_set;
    logic ff_clr;
    logic temp_rd;
    logic mclr;
    logic mcnt_clr;
    logic mask_clr;
    logic amask_rd;
    logic amask_wr;
  } dma_ev_t;

  // low three address bits when bit 3 is set
  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_REQ  = 3'd1;
  localparam logic [2:0] SEL_CMD  = 3'd2;
  localparam logic [2:0] SEL_MODE = 3'd3;
  localparam logic [2:0] SEL_FF   = 3'd4;
  localparam logic [2:0] SEL_TEMP = 3'd5;
  localparam logic [2:0] SEL_MISC = 3'd6;
  localparam logic [2:0] SEL_MASK = 3'd7;

endpackage

// File: rtl/dma_regif_decode.sv
module dma_regif_decode
  import dma_regif_pkg::*;
(
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [3:0] addr_i,
  output dma_ev_t    ev_o
);

  logic rd_acc, wr_acc;

  // exactly one strobe qualifies an access
  assign rd_acc = !cs_ni && !rd_ni &&  wr_ni;
  assign wr_acc = !cs_ni &&  rd_ni && !wr_ni;

  always_comb begin
    ev_o = '0;
    if (!addr_i[3]) begin
      ev_o.chan_rd = rd_acc;
      ev_o.chan_wr = wr_acc;
    end else begin
      unique case (addr_i[2:0])
        SEL_STAT: begin ev_o.stat_rd  = rd_acc; ev_o.cmd_wr   = wr_acc; end
        SEL_REQ:  begin ev_o.req_rd   = rd_acc; ev_o.req_wr   = wr_acc; end
        SEL_CMD:  begin ev_o.cmd_rd   = rd_acc; ev_o.smask_wr = wr_acc; end
        SEL_MODE: begin ev_o.mode_rd  = rd_acc; ev_o.mode_wr  = wr_acc; end
        SEL_FF:   begin ev_o.ff_set   = rd_acc; ev_o.ff_clr   = wr_acc; end
        SEL_TEMP: begin ev_o.temp_rd  = rd_acc; ev_o.mclr     = wr_acc; end
        SEL_MISC: begin ev_o.mcnt_clr = rd_acc; ev_o.mask_clr = wr_acc; end
        SEL_MASK: begin ev_o.amask_rd = rd_acc; ev_o.amask_wr = wr_acc; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan #(
  parameter int NCH    = 4,
  parameter int DATA_W = 8,
  localparam int CH_W   = $clog2(NCH),
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CH_W-1:0]       sel_i,
  input  logic                  cnt_sel_i,
  input  logic                  hi_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [NCH*WORD_W-1:0] addr_o,
  output logic [NCH*WORD_W-1:0] count_o,
  output logic [DATA_W-1:0]     rdata_o
);

  logic [WORD_W-1:0] addr_w  [NCH];
  logic [WORD_W-1:0] count_w [NCH];
  logic [WORD_W-1:0] word_sel;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [WORD_W-1:0] a_q, c_q;
    logic hit;
    assign hit = wr_en_i && (sel_i == CH_W'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        c_q <= '0;
      end else if (hit) begin
        if (cnt_sel_i) begin
          if (hi_i) c_q[WORD_W-1:DATA_W] <= data_i;
          else      c_q[DATA_W-1:0]      <= data_i;
        end else begin
          if (hi_i) a_q[WORD_W-1:DATA_W] <= data_i;
          else      a_q[DATA_W-1:0]      <= data_i;
        end
      end
    end

    assign addr_w[ch]  = a_q;
    assign count_w[ch] = c_q;
    assign addr_o [ch*WORD_W +: WORD_W] = a_q;
    assign count_o[ch*WORD_W +: WORD_W] = c_q;
  end

  assign word_sel = cnt_sel_i ? count_w[sel_i] : addr_w[sel_i];
  assign rdata_o  = hi_i ? word_sel[WORD_W-1:DATA_W] : word_sel[DATA_W-1:0];

endmodule

// File: rtl/dma_regif_status.sv
module dma_regif_status #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mclr_i,
  input  logic           rd_clr_i,
  input  logic [NCH-1:0] tc_i,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] tc_o,
  output logic [NCH-1:0] rq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_o <= '0;
      rq_o <= '0;
    end else if (mclr_i) begin
      tc_o <= '0;
      rq_o <= '0;
    end else begin
      // a new pulse wins over the read-clear
      tc_o <= (rd_clr_i ? '0 : tc_o) | tc_i;
      rq_o <= req_i;
    end
  end

endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8,
  localparam int CH_W   = $clog2(NCH),
  localparam int WORD_W = 2 * DATA_W,
  localparam int MODE_W = DATA_W - 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  rd_ni,
  input  logic                  wr_ni,
  input  logic [3:0]            addr_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [DATA_W-1:0]     data_o,
  input  logic [NCH-1:0]        tc_i,
  input  logic [NCH-1:0]        hw_req_i,
  input  logic                  temp_we_i,
  input  logic [DATA_W-1:0]     temp_i,
  output logic [DATA_W-1:0]     cmd_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH-1:0]        sw_req_o,
  output logic [NCH*WORD_W-1:0] chan_addr_o,
  output logic [NCH*WORD_W-1:0] chan_count_o,
  output logic                  mclr_o
);

  dma_ev_t           ev;
  logic [DATA_W-1:0] cmd_q, temp_q, chan_rdata;
  logic [NCH-1:0]    mask_q, req_q, stat_tc, stat_rq;
  logic [MODE_W-1:0] mode_q [NCH];
  logic [CH_W-1:0]   mcnt_q, dsel;
  logic              byte_hi_q;

  assign dsel = data_i[CH_W-1:0];

  dma_regif_decode u_dec (
    .cs_ni  (cs_ni),
    .rd_ni  (rd_ni),
    .wr_ni  (wr_ni),
    .addr_i (addr_i),
    .ev_o   (ev)
  );

  dma_regif_chan #(.NCH(NCH), .DATA_W(DATA_W)) u_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ev.chan_wr),
    .sel_i     (addr_i[CH_W:1]),
    .cnt_sel_i (addr_i[0]),
    .hi_i      (byte_hi_q),
    .data_i    (data_i),
    .addr_o    (chan_addr_o),
    .count_o   (chan_count_o),
    .rdata_o   (chan_rdata)
  );

  dma_regif_status #(.NCH(NCH)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mclr_i   (ev.mclr),
    .rd_clr_i (ev.stat_rd),
    .tc_i     (tc_i),
    .req_i    (hw_req_i | req_q),
    .tc_o     (stat_tc),
    .rq_o     (stat_rq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      mask_q    <= '1;
      req_q     <= '0;
      temp_q    <= '0;
      byte_hi_q <= 1'b0;
      mcnt_q    <= '0;
    end else if (ev.mclr) begin
      cmd_q     <= '0;
      mask_q    <= '1;
      req_q     <= '0;
      temp_q    <= '0;
      byte_hi_q <= 1'b0;
      mcnt_q    <= '0;
    end else begin
      if (ev.cmd_wr)    cmd_q <= data_i;
      if (temp_we_i)    temp_q <= temp_i;
      if (ev.req_wr)    req_q[dsel] <= data_i[CH_W];
      if (ev.mask_clr)      mask_q <= '0;
      else if (ev.amask_wr) mask_q <= data_i[NCH-1:0];
      else if (ev.smask_wr) mask_q[dsel] <= data_i[CH_W];
      if (ev.chan_rd || ev.chan_wr) byte_hi_q <= !byte_hi_q;
      else if (ev.ff_set)           byte_hi_q <= 1'b1;
      else if (ev.ff_clr)           byte_hi_q <= 1'b0;
      if (ev.mcnt_clr)     mcnt_q <= '0;
      else if (ev.mode_rd) mcnt_q <= mcnt_q + 1'b1;
    end
  end

  // mode registers survive master clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else if (ev.mode_wr) begin
      mode_q[dsel] <= data_i[DATA_W-1:2];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_mode
    assign mode_o[ch*MODE_W +: MODE_W] = mode_q[ch];
  end

  always_comb begin
    data_o = '0;
    if (ev.chan_rd)  data_o = chan_rdata;
    if (ev.stat_rd)  data_o[2*NCH-1:0] = {stat_rq, stat_tc};
    if (ev.req_rd)   data_o[NCH-1:0] = req_q;
    if (ev.cmd_rd)   data_o = cmd_q;
    if (ev.mode_rd)  data_o = {mode_q[mcnt_q], 2'b11};
    if (ev.temp_rd)  data_o = temp_q;
    if (ev.amask_rd) data_o[NCH-1:0] = mask_q;
  end

  assign cmd_o    = cmd_q;
  assign mask_o   = mask_q;
  assign sw_req_o = req_q;
  assign mclr_o   = ev.mclr;

endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk #(
  parameter int NCH    = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [3:0]        addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic [NCH-1:0]    tc_i,
  input logic [DATA_W-1:0] cmd_o,
  input logic [NCH-1:0]    mask_o,
  input logic [NCH-1:0]    sw_req_o,
  input logic              mclr_o,
  input logic [NCH-1:0]    stat_tc,
  input logic              byte_hi_q
);

  logic rd_acc, wr_acc;
  assign rd_acc = !cs_ni && !rd_ni && wr_ni;
  assign wr_acc = !cs_ni && rd_ni && !wr_ni;

  a_r5_tc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_i) && !mclr_o |=> ((stat_tc & $past(tc_i)) == $past(tc_i)));

  a_r11_mclr_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_o |=> (mask_o == '1) && (cmd_o == '0) && (sw_req_o == '0));

  a_r7_clear_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && addr_i == 4'hE |=> mask_o == '0);

  a_r6_cmd_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && addr_i == 4'h8 |=> cmd_o == $past(data_i));

  a_r9_mode_low_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc && addr_i == 4'hB |-> data_o[1:0] == 2'b11);

  a_r2_ff_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc || wr_acc) && !addr_i[3] |=> byte_hi_q != $past(byte_hi_q));

  a_r13_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(cmd_o) && $stable(mask_o) && $stable(sw_req_o) && $stable(byte_hi_q));

endmodule

bind dma_regif dma_regif_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .wr_ni     (wr_ni),
  .addr_i    (addr_i),
  .data_i    (data_i),
  .data_o    (data_o),
  .tc_i      (tc_i),
  .cmd_o     (cmd_o),
  .mask_o    (mask_o),
  .sw_req_o  (sw_req_o),
  .mclr_o    (mclr_o),
  .stat_tc   (stat_tc),
  .byte_hi_q (byte_hi_q)
);

// File: tb/tb_dma_regif.sv
module tb_dma_regif;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [3:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic [3:0]  tc_i = '0, hw_req_i = '0;
  logic        temp_we_i = 1'b0;
  logic [7:0]  temp_i = '0;
  logic [7:0]  cmd_o;
  logic [23:0] mode_o;
  logic [3:0]  mask_o, sw_req_o;
  logic [63:0] chan_addr_o, chan_count_o;
  logic        mclr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dma_regif dut (.*);

  // reference model state
  logic [7:0]  m_cmd, m_temp;
  logic [3:0]  m_mask, m_req, m_tc, m_rf;
  logic [5:0]  m_mode [4];
  logic [15:0] m_addr [4], m_cnt [4];
  logic        m_ff;
  logic [1:0]  m_mcnt;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cmd = 0; m_temp = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_rf = 0;
    m_ff = 0; m_mcnt = 0;
    for (int i = 0; i < 4; i++) begin m_mode[i] = 0; m_addr[i] = 0; m_cnt[i] = 0; end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [15:0] w;
    case (a)
      4'h8: return {m_rf, m_tc};
      4'h9: return {4'h0, m_req};
      4'hA: return m_cmd;
      4'hB: return {m_mode[m_mcnt], 2'b11};
      4'hD: return m_temp;
      4'hF: return {4'h0, m_mask};
      4'hC, 4'hE: return 8'h00;
      default: begin
        w = a[0] ? m_cnt[a[2:1]] : m_addr[a[2:1]];
        return m_ff ? w[15:8] : w[7:0];
      end
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    if (!a[3]) return "R2";
    case (a)
      4'h8: return "R4";  4'h9: return "R8";  4'hA: return "R6";
      4'hB: return "R9";  4'hD: return "R10"; 4'hF: return "R7";
      default: return "R12";
    endcase
  endfunction

  // compare then advance the model on every falling edge
  always @(negedge clk_i) begin
    logic rdx, wrx, mcl;
    logic [1:0] c;
    logic [3:0] ntc, nrf;
    rdx = !cs_ni && !rd_ni && wr_ni;
    wrx = !cs_ni && rd_ni && !wr_ni;
    mcl = wrx && addr_i == 4'hD;
    if (!rst_ni) model_reset();
    else begin
      chk(rdx ? rd_tag(addr_i) : "R13", data_o, rdx ? exp_rd(addr_i) : 8'h00);
      chk("R6", cmd_o, m_cmd);
      chk("R7", mask_o, m_mask);
      chk("R8", sw_req_o, m_req);
      chk("R9", mode_o, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
      chk("R2", chan_addr_o, {m_addr[3], m_addr[2], m_addr[1], m_addr[0]});
      chk("R2", chan_count_o, {m_cnt[3], m_cnt[2], m_cnt[1], m_cnt[0]});
      chk("R11", mclr_o, mcl);
      ntc = ((rdx && addr_i == 4'h8) ? 4'h0 : m_tc) | tc_i;
      nrf = hw_req_i | m_req;
      c = data_i[1:0];
      if (mcl) begin
        m_cmd = 0; m_req = 0; m_mask = 4'hF; m_ff = 0; m_mcnt = 0;
        m_tc = 0; m_rf = 0; m_temp = 0;
      end else begin
        m_tc = ntc; m_rf = nrf;
        if (temp_we_i) m_temp = temp_i;
        if ((rdx || wrx) && !addr_i[3]) begin
          if (wrx) begin
            if (addr_i[0]) begin
              if (m_ff) m_cnt[addr_i[2:1]][15:8] = data_i; else m_cnt[addr_i[2:1]][7:0] = data_i;
            end else begin
              if (m_ff) m_addr[addr_i[2:1]][15:8] = data_i; else m_addr[addr_i[2:1]][7:0] = data_i;
            end
          end
          m_ff = !m_ff;
        end
        if (wrx) case (addr_i)
          4'h8: m_cmd = data_i;
          4'h9: m_req[c] = data_i[2];
          4'hA: m_mask[c] = data_i[2];
          4'hB: m_mode[c] = data_i[7:2];
          4'hC: m_ff = 0;
          4'hE: m_mask = 0;
          4'hF: m_mask = data_i[3:0];
          default: ;
        endcase
        if (rdx) case (addr_i)
          4'hB: m_mcnt = m_mcnt + 1;
          4'hC: m_ff = 1;
          4'hE: m_mcnt = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk_i); #1; cs_ni = 0; wr_ni = 0; addr_i = a; data_i = d;
    @(posedge clk_i); #1; cs_ni = 1; wr_ni = 1;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk_i); #1; cs_ni = 0; rd_ni = 0; addr_i = a;
    @(negedge clk_i); #0.1; chk(tag, data_o, e);
    @(posedge clk_i); #1; cs_ni = 1; rd_ni = 1;
  endtask

  task automatic raw(input logic c, input logic r, input logic w, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk_i); #1; cs_ni = c; rd_ni = r; wr_ni = w; addr_i = a; data_i = d;
    @(posedge clk_i); #1; cs_ni = 1; rd_ni = 1; wr_ni = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    rd_exp(4'h8, 8'h00, "R1"); rd_exp(4'hF, 8'h0F, "R1");
    rd_exp(4'hA, 8'h00, "R1"); rd_exp(4'hD, 8'h00, "R1");
    rd_exp(4'h9, 8'h00, "R1");
    // R2 channel registers, low byte first
    wr(4'hC, 8'h5A);
    for (int ch = 0; ch < 4; ch++) begin
      wr(4'(2*ch), 8'(8'h10 + ch)); wr(4'(2*ch), 8'(8'h20 + ch));
      wr(4'(2*ch+1), 8'(8'h30 + ch)); wr(4'(2*ch+1), 8'(8'h40 + ch));
    end
    chk("R2", chan_addr_o[63:48], 16'h2313);
    chk("R2", chan_count_o[15:0], 16'h4030);
    rd_exp(4'h2, 8'h11, "R2"); rd_exp(4'h2, 8'h21, "R2");
    // R3 set flip-flop: high byte first
    rd_exp(4'hC, 8'h00, "R3");
    rd_exp(4'h5, 8'h42, "R3"); rd_exp(4'h5, 8'h32, "R3");
    wr(4'hC, 8'hFF);
    rd_exp(4'h6, 8'h13, "R3");
    wr(4'hC, 8'h00);
    // R6 command
    wr(4'h8, 8'hA5); rd_exp(4'hA, 8'hA5, "R6");
    // R7 masks
    wr(4'hA, 8'h01); rd_exp(4'hF, 8'h0D, "R7");
    wr(4'hA, 8'hFE); rd_exp(4'hF, 8'h0D, "R7");
    wr(4'hE, 8'hFF); rd_exp(4'hF, 8'h00, "R12");
    wr(4'hF, 8'hF6); rd_exp(4'hF, 8'h06, "R7");
    // R8 / R4 request bits and status
    wr(4'h9, 8'h06); rd_exp(4'h9, 8'h04, "R8");
    rd_exp(4'h8, 8'h40, "R4");
    @(posedge clk_i); #1 hw_req_i = 4'b0001;
    repeat (2) @(posedge clk_i);
    rd_exp(4'h8, 8'h50, "R4");
    // R5 terminal count
    @(posedge clk_i); #1 tc_i = 4'b1010;
    @(posedge clk_i); #1 tc_i = 4'b0000;
    rd_exp(4'h8, 8'h5A, "R5"); rd_exp(4'h8, 8'h50, "R5");
    @(posedge clk_i); #1; cs_ni = 0; rd_ni = 0; addr_i = 4'h8; tc_i = 4'b0001;
    @(negedge clk_i); #0.1; chk("R5", data_o, 8'h50);
    @(posedge clk_i); #1; cs_ni = 1; rd_ni = 1; tc_i = 0;
    rd_exp(4'h8, 8'h51, "R5"); rd_exp(4'h8, 8'h50, "R5");
    // R9 mode sequencer
    wr(4'hB, 8'h84); wr(4'hB, 8'h49); wr(4'hB, 8'hC2); wr(4'hB, 8'h17);
    rd_exp(4'hE, 8'h00, "R12");
    rd_exp(4'hB, 8'h87, "R9"); rd_exp(4'hB, 8'h4B, "R9");
    rd_exp(4'hB, 8'hC3, "R9"); rd_exp(4'hB, 8'h17, "R9");
    rd_exp(4'hB, 8'h87, "R9");
    rd_exp(4'hE, 8'h00, "R9"); rd_exp(4'hB, 8'h87, "R9");
    // R10 temporary register
    @(posedge clk_i); #1; temp_we_i = 1; temp_i = 8'h3C;
    @(posedge clk_i); #1; temp_we_i = 0; temp_i = 8'h00;
    rd_exp(4'hD, 8'h3C, "R10");
    // R11 master clear
    @(posedge clk_i); #1 hw_req_i = 0;
    rd_exp(4'hC, 8'h00, "R3");
    wr(4'hD, 8'h77);
    rd_exp(4'hF, 8'h0F, "R11"); rd_exp(4'hA, 8'h00, "R11");
    rd_exp(4'h9, 8'h00, "R11"); rd_exp(4'hD, 8'h00, "R11");
    rd_exp(4'h8, 8'h00, "R11");
    rd_exp(4'h2, 8'h11, "R11");
    rd_exp(4'hB, 8'h87, "R11");
    // R13 non-accesses
    raw(1'b1, 1'b1, 1'b0, 4'h8, 8'hFF); rd_exp(4'hA, 8'h00, "R13");
    raw(1'b0, 1'b0, 1'b0, 4'hF, 8'hF0); rd_exp(4'hF, 8'h0F, "R13");
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk_i); #1;
      cs_ni = ($urandom % 4) == 0;
      rd_ni = $urandom % 2;
      wr_ni = ($urandom % 8) == 0 ? rd_ni : !rd_ni;
      addr_i = 4'($urandom); data_i = 8'($urandom);
      tc_i = ($urandom % 4) == 0 ? 4'($urandom) : 4'h0;
      hw_req_i = 4'($urandom); temp_we_i = ($urandom % 8) == 0; temp_i = 8'($urandom);
    end
    @(posedge clk_i); #1; cs_ni = 1; rd_ni = 1; wr_ni = 1; tc_i = 0; temp_we_i = 0;
    repeat (2) @(posedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule